// File: doc/BRIEF.md
# Debug Command Word Sequencer

This block sits behind the serial link of a debug port and runs while the core is frozen. A front end outside the block assembles 16-bit words and signals each one with a one-cycle strobe. The sequencer reads the opcode from the first word of a command and works out how many extension words follow. It gathers those words and then runs the command. A command can read or write one of a small set of 32-bit system registers, read or write a memory location, or let the core resume.

The link is full duplex at the level of commands. Each command's result is loaded into the output shift register and goes out while the host sends the next word. When no result is waiting, that register holds an idle status word. Three other status words report the remaining cases:
- a word that arrived during a pending memory access,
- an unknown opcode,
- a command that completed with no data to return.

Memory is reached through a plain request/acknowledge port. The request stays high, with a stable address, until the acknowledge arrives.

Top module: `dbg_seq`

## Requirements
- R1: After reset, `shiftOut` holds the idle word 16'h7F00, and `memReq` and `resume` are low.
- R2: The opcode is bits [15:12] of a command's first word:
  - 1 reads a register (no extension words).
  - 2 writes a register (two extension words).
  - 3 reads memory (two extension words).
  - 4 writes memory (three extension words).
  - 5 resumes the core (no extension words).
  - Bits [2:0] pick the register. For a read, bit 4 picks the upper half (1) or the lower half (0).
- R3: A register read loads the selected 16-bit half into `shiftOut` at the clock edge that accepts the command word.
- R4: A register write stores {first extension, second extension} into the register. It loads the done word 16'h7F03 at the edge that accepts the last word.
- R5: A memory read raises `memReq` one cycle after its last word, with `memWe` low and `memAddr` = {first extension, second extension}. Request and address hold until `memAck`. At the acknowledge edge `memRdata` is loaded into `shiftOut` and `memReq` falls.
- R6: A memory write drives `memWe` high and puts the third extension word on `memWdata`. Its acknowledge loads the done word 16'h7F03.
- R7: A word that arrives while a memory access is pending and not acknowledged is dropped, and `shiftOut` becomes 16'h7F01.
- R8: A command word whose opcode is not 1 to 5 loads the illegal word 16'h7F02. Later words whose top nibble is not a legal opcode are discarded with the illegal word kept. The next word with a legal opcode starts a new command.
- R9: While `freeze` is low, words are ignored, `shiftOut` is forced to the idle word and any partly received command is abandoned.
- R10: A resume command drives `resume` high for the cycle after the edge that accepts it, and loads the done word.
- R11: A transfer that produces no new result (an extension word not yet completing a command) returns `shiftOut` to the idle word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | High while the core is in debug mode |
| wordValid | input | 1 | One-cycle strobe: `wordIn` holds a complete received word |
| wordIn | input | 16 | Received word |
| shiftOut | output | 16 | Word to be shifted out during the next transfer |
| resume | output | 1 | One-cycle request to leave debug mode |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data |
| memAck | input | 1 | Memory access complete |

## Verification
The hardest case to reach is a word that lands while a memory access is still waiting for its acknowledge. That word must be dropped and must return the not-ready word. The real result must then appear at the acknowledge edge.

The bench holds the acknowledge back by hand. It sends a register read into that window and checks the not-ready word. It then releases the acknowledge and confirms that the read data takes the output register and the request falls.

A second hard case is an abandoned command: freeze drops partway through a register write. The bench checks that the next word is taken as a fresh command word and not as a stray extension.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] ST_IDLE     = 16'h7F00;
  localparam logic [WORD_W-1:0] ST_NOTREADY = 16'h7F01;
  localparam logic [WORD_W-1:0] ST_ILLEGAL  = 16'h7F02;
  localparam logic [WORD_W-1:0] ST_DONE     = 16'h7F03;

  localparam logic [3:0] OP_RDREG  = 4'h1;
  localparam logic [3:0] OP_WRREG  = 4'h2;
  localparam logic [3:0] OP_RDMEM  = 4'h3;
  localparam logic [3:0] OP_WRMEM  = 4'h4;
  localparam logic [3:0] OP_RESUME = 4'h5;

  // selects what the output shift register loads at the coming edge
  typedef enum logic [2:0] {
    TX_KEEP, TX_IDLE, TX_REGRD, TX_DONE, TX_ILLEGAL, TX_NOTREADY, TX_MEMRD
  } tx_sel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       latchOp;
    logic       extWe;
    logic [1:0] extIdx;
    logic       regWe;
    logic       memStart;
    logic       memWrite;
    logic       memStop;
    tx_sel_e    txSel;
  } seq_strobe_t;

  function automatic logic opLegal(input logic [3:0] op);
    return (op >= OP_RDREG) && (op <= OP_RESUME);
  endfunction

  function automatic logic [1:0] extCount(input logic [3:0] op);
    case (op)
      OP_WRREG, OP_RDMEM: return 2'd2;
      OP_WRMEM:           return 2'd3;
      default:            return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        freeze,
  input  logic        wordValid,
  input  logic [3:0]  opField,
  input  logic        memAck,
  output seq_strobe_t strobe,
  output logic        resumePulse
);

  typedef enum logic [1:0] {S_OP, S_EXT, S_MEM, S_DISCARD} state_e;

  state_e     state, stateNext;
  logic [1:0] extLeft, extLeftNext;
  logic [1:0] extPos, extPosNext;
  logic [3:0] cmdOp, cmdOpNext;
  logic       resumeNext;
  logic       take;

  assign take = freeze && wordValid;

  always_comb begin
    strobe       = '0;
    strobe.txSel = TX_KEEP;
    stateNext    = state;
    extLeftNext  = extLeft;
    extPosNext   = extPos;
    cmdOpNext    = cmdOp;
    resumeNext   = 1'b0;

    // completion of a pending memory access, or a word that arrives too early
    if (state == S_MEM && memAck) begin
      strobe.memStop = 1'b1;
      strobe.txSel   = (cmdOp == OP_RDMEM) ? TX_MEMRD : TX_DONE;
      stateNext      = S_OP;
    end else if (state == S_MEM && take) begin
      strobe.txSel = TX_NOTREADY;
    end

    if (!freeze) begin
      strobe.txSel = TX_IDLE;
      if (state != S_MEM) stateNext = S_OP;
    end else if (take) begin
      case (state)
        S_OP, S_DISCARD: begin
          if (opLegal(opField)) begin
            strobe.latchOp = 1'b1;
            cmdOpNext      = opField;
            if (extCount(opField) == 2'd0) begin
              stateNext = S_OP;
              if (opField == OP_RDREG) begin
                strobe.txSel = TX_REGRD;
              end else begin
                strobe.txSel = TX_DONE;
                resumeNext   = 1'b1;
              end
            end else begin
              stateNext    = S_EXT;
              extLeftNext  = extCount(opField);
              extPosNext   = 2'd0;
              strobe.txSel = TX_IDLE;
            end
          end else begin
            strobe.txSel = TX_ILLEGAL;
            stateNext    = S_DISCARD;
          end
        end
        S_EXT: begin
          strobe.extWe  = 1'b1;
          strobe.extIdx = extPos;
          extPosNext    = extPos + 2'd1;
          extLeftNext   = extLeft - 2'd1;
          if (extLeft == 2'd1) begin
            if (cmdOp == OP_WRREG) begin
              strobe.regWe = 1'b1;
              strobe.txSel = TX_DONE;
              stateNext    = S_OP;
            end else begin
              strobe.memStart = 1'b1;
              strobe.memWrite = (cmdOp == OP_WRMEM);
              strobe.txSel    = TX_IDLE;
              stateNext       = S_MEM;
            end
          end else begin
            strobe.txSel = TX_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_OP;
      extLeft     <= 2'd0;
      extPos      <= 2'd0;
      cmdOp       <= 4'h0;
      resumePulse <= 1'b0;
    end else begin
      state       <= stateNext;
      extLeft     <= extLeftNext;
      extPos      <= extPosNext;
      cmdOp       <= cmdOpNext;
      resumePulse <= resumeNext;
    end
  end

  AST_RESUME_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> $past(take && opField == OP_RESUME)) else $error("resume without command"); // R10

  AST_ABANDON_UNFROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!freeze && state == S_EXT) |=> (state == S_OP)) else $error("partial command kept"); // R9

endmodule

// File: rtl/dbg_seq_dp.sv
module dbg_seq_dp
  import dbg_seq_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] shiftOut,
  output logic              memReq,
  output logic              memWe,
  output logic [2*WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);

  localparam int REG_AW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int REG_W   = 2 * WORD_W;
  localparam int EXT_NUM = 3;

  logic [WORD_W-1:0] extWord [EXT_NUM];
  logic [REG_W-1:0]  regFile [NUM_REGS];
  logic [REG_AW-1:0] wrIdx;
  logic [REG_W-1:0]  rdReg;
  logic [WORD_W-1:0] rdHalf;

  // extension word holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < EXT_NUM; k++) extWord[k] <= '0;
    end else if (strobe.extWe) begin
      for (int k = 0; k < EXT_NUM; k++)
        if (strobe.extIdx == 2'(k)) extWord[k] <= wordIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrIdx <= '0;
    else if (strobe.latchOp) wrIdx <= wordIn[REG_AW-1:0];
  end

  // system registers: the last word of a write arrives on wordIn
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_REGS; k++) regFile[k] <= '0;
    end else if (strobe.regWe) begin
      for (int k = 0; k < NUM_REGS; k++)
        if (32'(wrIdx) == k) regFile[k] <= {extWord[0], wordIn};
    end
  end

  // register read is decoded straight from the incoming command word
  always_comb begin
    rdReg = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (32'(wordIn[REG_AW-1:0]) == k) rdReg = regFile[k];
    rdHalf = wordIn[4] ? rdReg[REG_W-1:WORD_W] : rdReg[WORD_W-1:0];
  end

  assign memAddr  = {extWord[0], extWord[1]};
  assign memWdata = extWord[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq <= 1'b0;
      memWe  <= 1'b0;
    end else if (strobe.memStart) begin
      memReq <= 1'b1;
      memWe  <= strobe.memWrite;
    end else if (strobe.memStop) begin
      memReq <= 1'b0;
      memWe  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) shiftOut <= ST_IDLE;
    else begin
      case (strobe.txSel)
        TX_IDLE:     shiftOut <= ST_IDLE;
        TX_REGRD:    shiftOut <= rdHalf;
        TX_DONE:     shiftOut <= ST_DONE;
        TX_ILLEGAL:  shiftOut <= ST_ILLEGAL;
        TX_NOTREADY: shiftOut <= ST_NOTREADY;
        TX_MEMRD:    shiftOut <= memRdata;
        default:     ;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !strobe.memStop) |=> (memReq && $stable(memAddr) && $stable(memWe))) else $error("request dropped or moved"); // R5

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_seq_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        freeze,
  input  logic        wordValid,
  input  logic [15:0] wordIn,
  output logic [15:0] shiftOut,
  output logic        resume,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [15:0] memWdata,
  input  logic [15:0] memRdata,
  input  logic        memAck
);

  seq_strobe_t strobe;

  dbg_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .freeze      (freeze),
    .wordValid   (wordValid),
    .opField     (wordIn[15:12]),
    .memAck      (memAck),
    .strobe      (strobe),
    .resumePulse (resume)
  );

  dbg_seq_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordIn   (wordIn),
    .memRdata (memRdata),
    .shiftOut (shiftOut),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  AST_IDLE_UNFROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !freeze |=> (shiftOut == ST_IDLE)) else $error("output not idle outside debug"); // R9

  AST_NOTREADY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && freeze && wordValid) |=> (shiftOut == ST_NOTREADY)) else $error("busy word not flagged"); // R7

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !memReq) else $error("request held after ack"); // R5

endmodule

// File: tb/dbg_seq_test.sv
`timescale 1ns/1ps
module dbg_seq_test;
  import dbg_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        freeze = 1'b1;
  logic        wordValid = 1'b0;
  logic [15:0] wordIn = '0;
  logic [15:0] shiftOut;
  logic        resume, memReq, memWe;
  logic [31:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic        memAck = 1'b0;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  dbg_seq uut (
    .clk(clk), .rstN(rstN), .freeze(freeze), .wordValid(wordValid), .wordIn(wordIn),
    .shiftOut(shiftOut), .resume(resume), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  // {freeze, word sent, shiftOut expected after the accepting edge}
  localparam int NVEC = 17;
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 16'h2103, 16'h7F00},  // R11 write r3 opens, idle
    {1'b1, 16'hDEAD, 16'h7F00},  // R11 first extension
    {1'b1, 16'hBEEF, 16'h7F03},  // R4 write completes
    {1'b1, 16'h1013, 16'hDEAD},  // R3 upper half of r3
    {1'b1, 16'h1003, 16'hBEEF},  // R3 lower half of r3
    {1'b1, 16'h1000, 16'h0000},  // R2 r0 untouched
    {1'b1, 16'h7000, 16'h7F02},  // R8 illegal opcode
    {1'b1, 16'hF123, 16'h7F02},  // R8 discarded word
    {1'b1, 16'h1003, 16'hBEEF},  // R8 legal opcode restarts
    {1'b0, 16'h2105, 16'h7F00},  // R9 ignored while not frozen
    {1'b0, 16'h1003, 16'h7F00},  // R9 ignored
    {1'b1, 16'h1003, 16'hBEEF},  // R9 r3 kept, fresh command
    {1'b1, 16'h2105, 16'h7F00},  // R9 write r5 begins
    {1'b1, 16'h1234, 16'h7F00},  // R11 extension
    {1'b0, 16'h5678, 16'h7F00},  // R9 abandoned
    {1'b1, 16'h1005, 16'h0000},  // R9 taken as a command, r5 unwritten
    {1'b1, 16'h1103, 16'hBEEF}   // R2 bits above index ignored for read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic fr, input logic [15:0] w);
    @(negedge clk);
    freeze = fr; wordValid = 1'b1; wordIn = w;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic ackMem(input logic [15:0] data);
    memAck = 1'b1; memRdata = data;
    @(negedge clk);
    memAck = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 shiftOut", 32'(shiftOut), 32'h7F00);
    check("R1 memReq", 32'(memReq), 32'h0);
    check("R1 resume", 32'(resume), 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      sendWord(VEC[i][32], VEC[i][31:16]);
      check($sformatf("R3/R8/R9/R11 vector %0d", i), 32'(shiftOut), 32'(VEC[i][15:0]));
    end

    // R10 resume
    sendWord(1'b1, 16'h5000);
    check("R10 resume high", 32'(resume), 32'h1);
    check("R10 done word", 32'(shiftOut), 32'h7F03);
    @(negedge clk);
    check("R10 resume one cycle", 32'(resume), 32'h0);

    // R5 memory read with a busy word, R7
    sendWord(1'b1, 16'h3000);
    sendWord(1'b1, 16'h0012);
    sendWord(1'b1, 16'h3456);
    check("R5 request raised", 32'(memReq), 32'h1);
    check("R5 read address", memAddr, 32'h00123456);
    check("R5 read not write", 32'(memWe), 32'h0);
    check("R11 idle while pending", 32'(shiftOut), 32'h7F00);
    sendWord(1'b1, 16'h1003);
    check("R7 not ready word", 32'(shiftOut), 32'h7F01);
    check("R5 request held", 32'(memReq), 32'h1);
    check("R5 address held", memAddr, 32'h00123456);
    ackMem(16'h4C6B);
    check("R5 read data loaded", 32'(shiftOut), 32'h4C6B);
    check("R5 request dropped", 32'(memReq), 32'h0);
    sendWord(1'b1, 16'h1003);
    check("R7 dropped word, next taken fresh", 32'(shiftOut), 32'hBEEF);

    // R6 memory write
    sendWord(1'b1, 16'h4000);
    sendWord(1'b1, 16'h00AB);
    sendWord(1'b1, 16'hCDEF);
    sendWord(1'b1, 16'h1357);
    check("R6 request raised", 32'(memReq), 32'h1);
    check("R6 write flag", 32'(memWe), 32'h1);
    check("R6 write address", memAddr, 32'h00ABCDEF);
    check("R6 write data", 32'(memWdata), 32'h1357);
    repeat (3) @(negedge clk);
    check("R6 request waits for ack", 32'(memReq), 32'h1);
    ackMem(16'h0000);
    check("R6 done word", 32'(shiftOut), 32'h7F03);
    check("R6 request dropped", 32'(memReq), 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule